// File: doc/BRIEF.md
# ATA PIO host cycle sequencer

This block runs one programmed-I/O register access at a time on the host side of an IDE/ATA style device interface. A request carries a direction, two chip selects, a 3-bit register address, 16 bits of write data and a PIO mode from 0 to 4. The block turns the request into a timed bus cycle. It presents address and selects, pulses the active-low read or write strobe and drives or listens to the data bus. It finishes with a one-cycle done pulse that carries the read data and an error flag.

Each cycle has four phases: address setup, strobe active, tail and an enforced minimum cycle length. The tail covers address hold, write-data hold and strobe recovery. The timings are given in nanoseconds for each mode. They are converted to clock counts at elaboration time from the `CLK_NS` parameter by rounding up, and placed in a small table that the mode selects. The device can hold its ready line low to stretch the strobe. The block synchronizes that line with two flops. A stall that runs past a limit set at an input port ends the strobe early and flags an error.

The data bus is split into separate output, output-enable and input ports. The bidirectional pad sits outside the block.

Top module: `ata_pio_host`

## Requirements
- R1: After reset, and whenever the block is idle, `req_ready` is 1, both strobes and both chip-select outputs are 1, `ata_da` is 0, `ata_dd_oe` is 0 and `rsp_done` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle until the cycle before `rsp_done`, the outputs hold `ata_cs0_n = ~req_cs[0]`, `ata_cs1_n = ~req_cs[1]` and `ata_da = req_da`. The other strobe stays high throughout.
- R3: Counts come from `ceil(ns / CLK_NS)`. The per-mode nanosecond values for minimum cycle, setup, active, recovery, write hold and address hold are: 0 = 600/70/290/0/30/20, 1 = 383/50/290/0/20/15, 2 = 330/30/290/0/15/10, 3 = 180/30/80/70/10/10, 4 = 120/25/70/25/10/10. Counting the cycle after acceptance as cycle 1, the strobe is first low in cycle S+1. With IORDY high it stays low for exactly A cycles.
- R4: If the device holds `ata_iordy` low for D ≥ 1 cycles, starting with the first strobe-low cycle, the strobe stays low for max(A, D+3) cycles. This holds when no timeout occurs.
- R5: Let W be the strobe width and Hr = max(address hold, write hold, recovery). Then `rsp_done` and `req_ready` rise in cycle N+1, where N = max(S+W+Hr, C).
- R6: On a write, `ata_dd_oe` is 1 with `ata_dd_out = req_wdata` from cycle 1 through the write-hold count of cycles after the last strobe-low cycle. It is 0 afterwards.
- R7: On a read, `ata_dd_oe` stays 0. `rsp_rdata` equals `ata_dd_in` as sampled in the last strobe-low cycle, and is valid when `rsp_done` is 1.
- R8: Only strobe-low cycles at or after cycle A of the strobe, with the synchronized IORDY low, count as stall cycles. Let L be `stall_limit`, with 0 acting as 1. When the stall count reaches L, the strobe ends after A-1+L low cycles and `rsp_err` is 1 with `rsp_done`. Otherwise `rsp_err` is 0.
- R9: Mode values 5 to 7 use the mode 0 timing.
- R10: Only one cycle is in flight. `req_ready` is 0 from the cycle after acceptance until the cycle of `rsp_done`.
- R11: The read and write strobes are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip selects, active high (bit 0, bit 1) |
| req_da | input | 3 | Register address |
| req_wdata | input | 16 | Write data |
| req_mode | input | 3 | PIO mode |
| stall_limit | input | 8 | Stall cycles allowed before abort |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion ended by timeout |
| rsp_rdata | output | 16 | Read data |
| ata_da | output | 3 | Device address lines |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data bus drive value |
| ata_dd_oe | output | 1 | Data bus drive enable |
| ata_dd_in | input | 16 | Data bus sampled value |
| ata_iordy | input | 1 | Device ready, low stretches the strobe |

## Verification
The timeout decision and the return of IORDY can land on neighbouring strobe cycles. The limit may be reached in the last stalled cycle, just before the synchronized ready comes back. The bench provokes this in mode 4 with a limit of 5 by holding IORDY low for 10 cycles (four stalls, completes cleanly) and then for 11 cycles (five stalls, aborts). Both cases give a 13-cycle strobe, so only `rsp_err` and the timing of done tell them apart. The bench judges them against its own stall-count formula.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int NUM_MODES = 5;
  localparam int CNT_W     = 8;

  typedef logic [CNT_W-1:0] cnt_t;

  // all counts in clock cycles; tail = max(address hold, write hold, recovery)
  typedef struct packed {
    cnt_t setup;
    cnt_t active;
    cnt_t tail;
    cnt_t whold;
    cnt_t cycle;
  } timing_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACTIVE, ST_TAIL} phase_e;

  function automatic int ns_to_cycles(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic cnt_t clip(int v, int floor_v);
    int t;
    t = (v < floor_v) ? floor_v : v;
    if (t > (1 << CNT_W) - 1) t = (1 << CNT_W) - 1;
    return cnt_t'(t);
  endfunction

  function automatic timing_t timing_for(int mode, int clk_ns);
    int cyc, su, act, rec, wh, ah, tl;
    timing_t t;
    case (mode)
      1:       begin cyc = 383; su = 50; act = 290; rec = 0;  wh = 20; ah = 15; end
      2:       begin cyc = 330; su = 30; act = 290; rec = 0;  wh = 15; ah = 10; end
      3:       begin cyc = 180; su = 30; act = 80;  rec = 70; wh = 10; ah = 10; end
      4:       begin cyc = 120; su = 25; act = 70;  rec = 25; wh = 10; ah = 10; end
      default: begin cyc = 600; su = 70; act = 290; rec = 0;  wh = 30; ah = 20; end
    endcase
    tl = ah;
    if (wh > tl) tl = wh;
    if (rec > tl) tl = rec;
    t.setup  = clip(ns_to_cycles(su, clk_ns), 1);
    t.active = clip(ns_to_cycles(act, clk_ns), 1);
    t.tail   = clip(ns_to_cycles(tl, clk_ns), 1);
    t.whold  = clip(ns_to_cycles(wh, clk_ns), 1);
    t.cycle  = clip(ns_to_cycles(cyc, clk_ns), 1);
    return t;
  endfunction
endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RESET_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode,
  output timing_t           tim
);
  timing_t rom [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_rom
    assign rom[g] = timing_for(g, CLK_NS);
  end

  // out-of-range modes keep the entry 0 default
  always_comb begin
    tim = rom[0];
    for (int i = 1; i < NUM_MODES; i++)
      if (mode == MODE_W'(i)) tim = rom[i];
  end
endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
  import ata_pio_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  logic [1:0]       start_cs,
  input  logic [2:0]       start_da,
  input  logic [DW-1:0]    start_wdata,
  input  timing_t          start_tim,
  input  logic             iordy_s,
  input  logic [LIM_W-1:0] stall_limit,
  input  logic [DW-1:0]    dd_in,
  output logic             idle,
  output logic [2:0]       da,
  output logic             cs0_n,
  output logic             cs1_n,
  output logic             dior_n,
  output logic             diow_n,
  output logic [DW-1:0]    dd_out,
  output logic             dd_oe,
  output logic             done,
  output logic             err,
  output logic [DW-1:0]    rdata,
  output logic             ev_strobe_end,
  output logic             ev_abort
);
  phase_e           st;
  logic             wr;
  logic             aborted;
  timing_t          tim;
  cnt_t             pcnt;
  cnt_t             tcnt;
  logic [LIM_W-1:0] stall_cnt;
  logic [LIM_W:0]   stall_next;
  logic             act_min;
  logic             stalled;
  logic             tail_end;

  assign act_min       = (st == ST_ACTIVE) && (pcnt >= tim.active - 1'b1);
  assign stalled       = act_min && !iordy_s;
  assign stall_next    = {1'b0, stall_cnt} + 1'b1;
  assign ev_abort      = stalled && (stall_next >= {1'b0, stall_limit});
  assign ev_strobe_end = act_min && (iordy_s || ev_abort);
  assign tail_end      = (st == ST_TAIL) && (pcnt >= tim.tail - 1'b1) && (tcnt >= tim.cycle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wr        <= 1'b0;
      aborted   <= 1'b0;
      tim       <= '0;
      pcnt      <= '0;
      tcnt      <= '0;
      stall_cnt <= '0;
      da        <= '0;
      cs0_n     <= 1'b1;
      cs1_n     <= 1'b1;
      dd_out    <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (st != ST_IDLE && tcnt != '1) tcnt <= tcnt + 1'b1;
      unique case (st)
        ST_IDLE: if (start) begin
          st        <= ST_SETUP;
          wr        <= start_write;
          aborted   <= 1'b0;
          tim       <= start_tim;
          pcnt      <= '0;
          tcnt      <= cnt_t'(1);
          stall_cnt <= '0;
          da        <= start_da;
          cs0_n     <= ~start_cs[0];
          cs1_n     <= ~start_cs[1];
          dd_out    <= start_wdata;
        end
        ST_SETUP: begin
          if (pcnt >= tim.setup - 1'b1) begin
            st   <= ST_ACTIVE;
            pcnt <= '0;
          end else pcnt <= pcnt + 1'b1;
        end
        ST_ACTIVE: begin
          if (ev_strobe_end) begin
            st      <= ST_TAIL;
            pcnt    <= '0;
            aborted <= ev_abort;
            if (!wr) rdata <= dd_in;
          end else if (stalled) stall_cnt <= stall_cnt + 1'b1;
          else pcnt <= pcnt + 1'b1;
        end
        ST_TAIL: begin
          if (tail_end) begin
            st    <= ST_IDLE;
            done  <= 1'b1;
            err   <= aborted;
            da    <= '0;
            cs0_n <= 1'b1;
            cs1_n <= 1'b1;
          end else if (pcnt != '1) pcnt <= pcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle   = (st == ST_IDLE);
  assign dior_n = !((st == ST_ACTIVE) && !wr);
  assign diow_n = !((st == ST_ACTIVE) && wr);
  assign dd_oe  = wr && ((st == ST_SETUP) || (st == ST_ACTIVE) ||
                         ((st == ST_TAIL) && (pcnt < tim.whold)));
endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
  import ata_pio_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int DW     = 16,
  parameter int MODE_W = 3,
  parameter int LIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_cs,
  input  logic [2:0]        req_da,
  input  logic [DW-1:0]     req_wdata,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [LIM_W-1:0]  stall_limit,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata,
  output logic [2:0]        ata_da,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DW-1:0]     ata_dd_out,
  output logic              ata_dd_oe,
  input  logic [DW-1:0]     ata_dd_in,
  input  logic              ata_iordy
);
  timing_t req_tim;
  logic    ev_accept;
  logic    iordy_s;
  logic    ev_strobe_end;
  logic    ev_abort;
  logic    idle;

  assign req_ready = idle;
  assign ev_accept = req_valid && idle;

  ata_pio_timing #(.CLK_NS(CLK_NS), .MODE_W(MODE_W)) timing_i (
    .mode (req_mode),
    .tim  (req_tim)
  );

  ata_pio_sync #(.STAGES(2), .RESET_VAL(1'b1)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ata_iordy),
    .q     (iordy_s)
  );

  ata_pio_fsm #(.DW(DW), .LIM_W(LIM_W)) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (ev_accept),
    .start_write   (req_write),
    .start_cs      (req_cs),
    .start_da      (req_da),
    .start_wdata   (req_wdata),
    .start_tim     (req_tim),
    .iordy_s       (iordy_s),
    .stall_limit   (stall_limit),
    .dd_in         (ata_dd_in),
    .idle          (idle),
    .da            (ata_da),
    .cs0_n         (ata_cs0_n),
    .cs1_n         (ata_cs1_n),
    .dior_n        (ata_dior_n),
    .diow_n        (ata_diow_n),
    .dd_out        (ata_dd_out),
    .dd_oe         (ata_dd_oe),
    .done          (rsp_done),
    .err           (rsp_err),
    .rdata         (rsp_rdata),
    .ev_strobe_end (ev_strobe_end),
    .ev_abort      (ev_abort)
  );
endmodule

// File: rtl/ata_pio_host_chk.sv
module ata_pio_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       ev_accept,
  input logic       rsp_done,
  input logic       rsp_err,
  input logic [2:0] ata_da,
  input logic       ata_cs0_n,
  input logic       ata_cs1_n,
  input logic       ata_dior_n,
  input logic       ata_diow_n,
  input logic       ata_dd_oe,
  input logic       iordy_s,
  input logic       ev_strobe_end,
  input logic       ev_abort
);
  logic strobe_low;
  assign strobe_low = !ata_dior_n || !ata_diow_n;

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ata_dior_n && ata_diow_n && ata_cs0_n && ata_cs1_n && !ata_dd_oe));

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_low && $past(strobe_low)) |-> $stable({ata_cs1_n, ata_cs0_n, ata_da}));

  p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_low && !iordy_s && !ev_abort) |=> strobe_low);

  p_strobe_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe_end |=> (ata_dior_n && ata_diow_n));

  p_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_diow_n |-> ata_dd_oe);

  p_read_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_dior_n |-> !ata_dd_oe);

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);

  p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));
endmodule

bind ata_pio_host ata_pio_host_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .ev_accept     (ev_accept),
  .rsp_done      (rsp_done),
  .rsp_err       (rsp_err),
  .ata_da        (ata_da),
  .ata_cs0_n     (ata_cs0_n),
  .ata_cs1_n     (ata_cs1_n),
  .ata_dior_n    (ata_dior_n),
  .ata_diow_n    (ata_diow_n),
  .ata_dd_oe     (ata_dd_oe),
  .iordy_s       (iordy_s),
  .ev_strobe_end (ev_strobe_end),
  .ev_abort      (ev_abort)
);

// File: tb/ata_pio_host_tb_top.sv
module ata_pio_host_tb_top;
  localparam int CLK = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_cs = '0;
  logic [2:0]  req_da = '0;
  logic [15:0] req_wdata = '0;
  logic [2:0]  req_mode = '0;
  logic [7:0]  stall_limit = 8'd20;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic [2:0]  ata_da;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n;
  logic [15:0] ata_dd_out;
  logic        ata_dd_oe;
  logic [15:0] ata_dd_in;
  logic        ata_iordy;

  int n_chk = 0;
  int n_bad = 0;
  int dev_delay = 0;
  int lowcnt = 0;
  bit finished = 0;
  logic [15:0] dev_mem [32];
  logic [15:0] exp_mem [32];

  always #4 clk = ~clk;

  ata_pio_host #(.CLK_NS(CLK)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cs(req_cs), .req_da(req_da), .req_wdata(req_wdata),
    .req_mode(req_mode), .stall_limit(stall_limit), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ata_da(ata_da),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_dior_n(ata_dior_n),
    .ata_diow_n(ata_diow_n), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
    .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
  );

  // device model: register file, ready line held low for dev_delay strobe cycles
  logic strobe_low;
  logic [4:0] dev_addr;
  assign strobe_low = !ata_dior_n || !ata_diow_n;
  assign dev_addr   = {~ata_cs1_n, ~ata_cs0_n, ata_da};
  assign ata_iordy  = !(strobe_low && (lowcnt < dev_delay));
  assign ata_dd_in  = !ata_dior_n ? dev_mem[dev_addr] : 16'h5A5A;

  always @(posedge clk) lowcnt <= strobe_low ? lowcnt + 1 : 0;

  always @(posedge ata_diow_n) if (rst_n) dev_mem[dev_addr] = ata_dd_out;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int up_div(int ns);
    int q;
    q = ns / CLK;
    if (q * CLK < ns) q = q + 1;
    return q;
  endfunction

  // columns: min cycle, setup, active, recovery, write hold, address hold
  function automatic void mode_ns(input int m, output int c, output int s, output int a,
                                  output int r, output int wh, output int ah);
    case (m)
      4: begin c = 120; s = 25; a = 70;  r = 25; wh = 10; ah = 10; end
      3: begin c = 180; s = 30; a = 80;  r = 70; wh = 10; ah = 10; end
      2: begin c = 330; s = 30; a = 290; r = 0;  wh = 15; ah = 10; end
      1: begin c = 383; s = 50; a = 290; r = 0;  wh = 20; ah = 15; end
      default: begin c = 600; s = 70; a = 290; r = 0; wh = 30; ah = 20; end
    endcase
  endfunction

  task automatic run_cycle(input bit wr, input logic [1:0] cs, input logic [2:0] da,
                           input logic [15:0] wd, input logic [2:0] mode, input int d);
    int cn, sn, an, rn, whn, ahn, m;
    int S, A, C, WH, HR, W, N, L, stalls;
    bit exp_err;
    int fall, width, done_k, line_bad, oe_bad, busy_bad;
    logic [15:0] got_rd;
    logic got_err;
    logic [4:0] adr;
    m = (mode > 4) ? 0 : int'(mode);
    mode_ns(m, cn, sn, an, rn, whn, ahn);
    S = up_div(sn); A = up_div(an); C = up_div(cn); WH = up_div(whn);
    HR = up_div(ahn);
    if (up_div(whn) > HR) HR = up_div(whn);
    if (up_div(rn) > HR) HR = up_div(rn);
    L = (stall_limit == 0) ? 1 : int'(stall_limit);
    stalls = (d == 0) ? 0 : d + 3 - A;
    if (stalls < 0) stalls = 0;
    exp_err = (stalls >= L);
    if (exp_err) W = A - 1 + L;
    else W = (d == 0 || A > d + 3) ? A : d + 3;
    N = S + W + HR;
    if (C > N) N = C;
    adr = {cs[1], cs[0], da};

    dev_delay = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cs = cs; req_da = da;
    req_wdata = wd; req_mode = mode;
    @(negedge clk);
    req_valid = 1'b0;
    fall = 0; width = 0; done_k = 0; line_bad = 0; oe_bad = 0; busy_bad = 0;
    got_rd = '0; got_err = 1'b0;
    for (int k = 1; k < 3000; k++) begin
      if (rsp_done) begin
        done_k = k; got_rd = rsp_rdata; got_err = rsp_err;
        break;
      end
      if (req_ready) busy_bad++;
      if (ata_cs0_n != ~cs[0] || ata_cs1_n != ~cs[1] || ata_da != da) line_bad++;
      if (wr ? !ata_dior_n : !ata_diow_n) line_bad++;
      if (wr ? !ata_diow_n : !ata_dior_n) begin
        if (fall == 0) fall = k;
        width++;
      end
      if (ata_dd_oe != (wr && k <= S + W + WH)) oe_bad++;
      if (ata_dd_oe && ata_dd_out != wd) oe_bad++;
      @(negedge clk);
    end
    check(fall == S + 1, (mode > 4) ? "R9 strobe fall (mode above 4)" : "R3 strobe fall", fall, S + 1);
    check(width == W, (d == 0) ? "R3 strobe width" : (exp_err ? "R8 aborted strobe width" : "R4 stretched width"), width, W);
    check(done_k == N + 1, "R5 done cycle", done_k, N + 1);
    check(got_err == exp_err, "R8 error flag", int'(got_err), int'(exp_err));
    check(line_bad == 0, "R2 address/select lines", line_bad, 0);
    check(busy_bad == 0, "R10 ready low while busy", busy_bad, 0);
    check(oe_bad == 0, wr ? "R6 write drive window" : "R7 read bus released", oe_bad, 0);
    check(ata_dior_n && ata_diow_n && ata_cs0_n && ata_cs1_n && !ata_dd_oe && req_ready && ata_da == 0,
          "R1 idle lines at done", 0, 0);
    if (wr) exp_mem[adr] = wd;
    else check(got_rd == exp_mem[adr], "R7 read data", int'(got_rd), int'(exp_mem[adr]));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      dev_mem[i] = 16'hC300 + 16'(i * 7);
      exp_mem[i] = 16'hC300 + 16'(i * 7);
    end
    void'($urandom(32'd1103));
    repeat (3) @(negedge clk);
    check(req_ready && ata_dior_n && ata_diow_n && ata_cs0_n && ata_cs1_n && !ata_dd_oe && !rsp_done,
          "R1 in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && ata_dior_n && ata_diow_n && ata_cs0_n && ata_cs1_n && !ata_dd_oe &&
          !rsp_done && ata_da == 0, "R1 after reset", 0, 0);

    stall_limit = 8'd20;
    run_cycle(1'b1, 2'b01, 3'd2, 16'hBEEF, 3'd0, 0);
    run_cycle(1'b0, 2'b01, 3'd2, 16'h0000, 3'd4, 0);
    run_cycle(1'b1, 2'b10, 3'd6, 16'h1234, 3'd3, 0);
    run_cycle(1'b0, 2'b10, 3'd6, 16'h0000, 3'd3, 0);
    run_cycle(1'b0, 2'b11, 3'd5, 16'h0000, 3'd7, 0);
    run_cycle(1'b1, 2'b00, 3'd1, 16'h8001, 3'd5, 0);
    run_cycle(1'b0, 2'b01, 3'd7, 16'h0000, 3'd4, 20);
    stall_limit = 8'd5;
    run_cycle(1'b0, 2'b01, 3'd3, 16'h0000, 3'd4, 40);
    run_cycle(1'b0, 2'b01, 3'd3, 16'h0000, 3'd4, 10);
    run_cycle(1'b1, 2'b01, 3'd3, 16'h7777, 3'd4, 11);
    stall_limit = 8'd0;
    run_cycle(1'b0, 2'b01, 3'd0, 16'h0000, 3'd4, 30);
    stall_limit = 8'd20;
    for (int t = 0; t < 40; t++) begin
      int dd;
      dd = ($urandom % 2) ? 0 : int'($urandom % 16);
      run_cycle(1'($urandom % 2), 2'($urandom % 4), 3'($urandom % 8),
                16'($urandom), 3'($urandom % 8), dd);
    end
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule